// File: doc/BRIEF.md
# MDIO Managed-Device Responder

This block sits on the device side of a two-wire management bus. It watches the management clock and the shared data line, hunts for a run of ones that precedes every frame, and then decodes either the short frame format (start field 01, 5-bit register number) or the extended format (start field 00, 5-bit device number plus a 16-bit per-device address pointer). Frames carrying a port address other than the block's own strap value are dropped without ever touching the line.

Read frames are answered by releasing the line for the first turnaround bit, pulling it low for the second, and then shifting out sixteen data bits, most significant first. Write frames are received and applied to a small bank of 16-bit words. The same bank is reachable from the local side through a single-cycle register port. Both clock and data are resynchronised to the system clock, so the bus clock must be several times slower than the system clock. Output enable and output data feed an external tristate pad.

Top module: `mdio_slave_resp`

## Requirements
- R1: After reset the output enable is low, the output is 0 and every bank word reads 0000 on the local port.
- R2: A start field is accepted only after at least 32 consecutive ones have been sampled; a frame preceded by fewer ones is ignored entirely (no write, no drive).
- R3: A short-format frame (start 01) with opcode 01 and a matching port address writes its 16 data bits to bank word equal to the register field, when that field is below 8.
- R4: On an accepted read, the line is undriven during the first turnaround bit, driven 0 during the second, then driven with the 16 data bits MSB first, each bit changed after a falling bus clock edge; the drive stops after the falling edge that follows the last data bit.
- R5: A frame whose 5-bit port address differs from `own_addr` writes nothing and never asserts the output enable.
- R6: In the extended format (start 00), opcode 00 loads the 16-bit data into the pointer of the device field, opcode 01 writes the word at that pointer, opcode 10 reads it.
- R7: Extended opcode 11 reads the word at the pointer and then adds one to the pointer; FFFF wraps to 0000.
- R8: Each of the 32 device field values keeps its own pointer; loading one leaves the others unchanged.
- R9: Bank mapping: short register r (r < 8) is word r; extended device d (1..2) address a (a < 8) is word 8 + 8*(d-1) + a. Any other register, device or pointer value reads 0000 and ignores writes.
- R10: A short-format opcode of 00 or 11, or a write/address-load frame whose turnaround field is not 10, discards the frame without writes and without drive, and the block resumes preamble hunting.
- R11: The local port writes word `loc_addr` with `loc_wdata` when `loc_we` is high and reads word `loc_addr` combinationally on `loc_rdata`; indices 24 and above read 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 5 | Port address this responder answers to |
| mdc_in | input | 1 | Management bus clock |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_out | output | 1 | Value driven onto the line when enabled |
| mdio_oe | output | 1 | Pad output enable |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 5 | Local word index |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data (combinational) |

## Verification
Both bus lines pass two synchroniser stages and an edge register, so the pad outputs change three system cycles after a bus clock edge and a received write lands in the bank three cycles after the rising edge of its last data bit. The bench holds each half of the bus clock for eight system cycles and samples the pad at the end of the low half, five cycles after the output is due. Bank contents are read on the local port only after a trailing idle bit, well past the write, and turnaround and release checks are taken in the exact bit periods named in R4.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  localparam int DW       = 16;  // data field width
  localparam int HDR_BITS = 12;  // opcode + port + register/device
  localparam int NDEVADDR = 32;  // pointer count (5-bit device field)

  typedef enum logic [2:0] {
    PH_HUNT, PH_ST2, PH_HDR, PH_TA1, PH_TA2, PH_DATA
  } phase_e;

  // header acceptance: short format only knows read and write
  function automatic logic op_valid(input logic c45, input logic [1:0] op);
    return c45 || (op == 2'b01) || (op == 2'b10);
  endfunction

  function automatic logic op_is_read(input logic c45, input logic [1:0] op);
    return c45 ? op[1] : (op == 2'b10);
  endfunction

  function automatic logic ta_good(input logic first, input logic second);
    return first && !second;
  endfunction

  function automatic logic bank_hit(input logic c45, input logic [4:0] rf,
                                    input logic [15:0] ptr, input int n22,
                                    input int ndev, input int nw45);
    if (!c45) return int'(rf) < n22;
    return (int'(rf) >= 1) && (int'(rf) <= ndev) && (int'(ptr) < nw45);
  endfunction

  function automatic int bank_index(input logic c45, input logic [4:0] rf,
                                    input logic [15:0] ptr, input int n22,
                                    input int nw45);
    if (!c45) return int'(rf);
    return n22 + (int'(rf) - 1) * nw45 + int'(ptr);
  endfunction

  function automatic logic [15:0] ptr_next(input logic [15:0] p);
    return p + 16'd1;
  endfunction

endpackage

// File: rtl/mdio_resp_sync.sv
module mdio_resp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_in,
  input  logic mdio_in,
  output logic rise_evt,
  output logic fall_evt,
  output logic bit_in
);
  logic [STAGES-1:0] mdc_sh;
  logic [STAGES-1:0] dat_sh;
  logic              mdc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh <= '0;
      dat_sh <= '0;
      mdc_d  <= 1'b0;
    end else begin
      mdc_sh <= {mdc_sh[STAGES-2:0], mdc_in};
      dat_sh <= {dat_sh[STAGES-2:0], mdio_in};
      mdc_d  <= mdc_sh[STAGES-1];
    end
  end

  assign rise_evt = mdc_sh[STAGES-1] && !mdc_d;
  assign fall_evt = !mdc_sh[STAGES-1] && mdc_d;
  assign bit_in   = dat_sh[STAGES-1];

  a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/mdio_resp_frame.sv
module mdio_resp_frame import mdio_resp_pkg::*; #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_evt,
  input  logic        bit_in,
  input  logic [4:0]  own_addr,
  output phase_e      phase,
  output logic        rd_frame,
  output logic        is_c45,
  output logic [4:0]  rf,
  output logic [DW-1:0] wdata,
  output logic        wr_evt,
  output logic        addr_evt,
  output logic        inc_evt,
  output logic        rd_load
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int CW  = $clog2(DW);

  logic [PCW-1:0]      ones_cnt;
  logic [CW-1:0]       cnt;
  logic [HDR_BITS-2:0] hdr_sh;
  logic [DW-2:0]       data_sh;
  logic [1:0]          op_q;
  logic                ta1_bit;

  // named internal events
  logic [HDR_BITS-1:0] hdr_full;
  logic [1:0]          hdr_op;
  logic [4:0]          hdr_pa;
  logic [4:0]          hdr_rf;
  logic                pre_full, hdr_last, addr_match, hdr_ok, data_last, frame_done;

  assign pre_full   = (ones_cnt == PCW'(PRE_LEN));
  assign hdr_full   = {hdr_sh, bit_in};
  assign hdr_op     = hdr_full[11:10];
  assign hdr_pa     = hdr_full[9:5];
  assign hdr_rf     = hdr_full[4:0];
  assign hdr_last   = (phase == PH_HDR) && (cnt == CW'(HDR_BITS - 1));
  assign addr_match = (hdr_pa == own_addr);
  assign hdr_ok     = addr_match && op_valid(is_c45, hdr_op);
  assign data_last  = (phase == PH_DATA) && (cnt == CW'(DW - 1));
  assign frame_done = rise_evt && data_last;
  assign wdata      = {data_sh, bit_in};

  assign wr_evt   = frame_done && (op_q == 2'b01);
  assign addr_evt = frame_done && is_c45 && (op_q == 2'b00);
  assign inc_evt  = frame_done && is_c45 && (op_q == 2'b11);
  assign rd_load  = rise_evt && (phase == PH_TA1) && rd_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HUNT;
      ones_cnt <= '0;
      cnt      <= '0;
      hdr_sh   <= '0;
      data_sh  <= '0;
      op_q     <= 2'b00;
      rf       <= 5'd0;
      is_c45   <= 1'b0;
      rd_frame <= 1'b0;
      ta1_bit  <= 1'b0;
    end else if (rise_evt) begin
      case (phase)
        PH_HUNT: begin
          if (bit_in) begin
            if (!pre_full) ones_cnt <= ones_cnt + 1'b1;
          end else begin
            ones_cnt <= '0;
            if (pre_full) phase <= PH_ST2;
          end
        end
        PH_ST2: begin
          is_c45 <= !bit_in;
          cnt    <= '0;
          phase  <= PH_HDR;
        end
        PH_HDR: begin
          hdr_sh <= hdr_full[HDR_BITS-2:0];
          cnt    <= cnt + 1'b1;
          if (hdr_last) begin
            if (hdr_ok) begin
              op_q     <= hdr_op;
              rf       <= hdr_rf;
              rd_frame <= op_is_read(is_c45, hdr_op);
              phase    <= PH_TA1;
            end else begin
              phase <= PH_HUNT;
            end
          end
        end
        PH_TA1: begin
          ta1_bit <= bit_in;
          phase   <= PH_TA2;
        end
        PH_TA2: begin
          cnt   <= '0;
          phase <= (rd_frame || ta_good(ta1_bit, bit_in)) ? PH_DATA : PH_HUNT;
        end
        PH_DATA: begin
          data_sh <= wdata[DW-2:0];
          cnt     <= cnt + 1'b1;
          if (data_last) phase <= PH_HUNT;
        end
        default: phase <= PH_HUNT;
      endcase
    end
  end

  a_r2_full_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && phase == PH_HUNT && !bit_in && ones_cnt != PCW'(PRE_LEN)) |=> phase == PH_HUNT);
  a_r5_mismatch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && hdr_last && !addr_match) |=> phase == PH_HUNT);
  a_r10_bad_ta_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && phase == PH_TA2 && !rd_frame && !(ta1_bit && !bit_in)) |=> phase == PH_HUNT);
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_evt, addr_evt, inc_evt}) <= 1);
endmodule

// File: rtl/mdio_resp_regs.sv
module mdio_resp_regs import mdio_resp_pkg::*; #(
  parameter int C22_REGS  = 8,
  parameter int C45_DEVS  = 2,
  parameter int C45_WORDS = 8,
  localparam int NW = C22_REGS + C45_DEVS * C45_WORDS,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_c45,
  input  logic [4:0]    rf,
  input  logic [DW-1:0] wdata,
  input  logic          wr_evt,
  input  logic          addr_evt,
  input  logic          inc_evt,
  output logic [DW-1:0] rd_word,
  input  logic          loc_we,
  input  logic [IW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic [NW-1:0][DW-1:0]       bank;
  logic [NDEVADDR-1:0][15:0]   ptr;

  logic [15:0]   ptr_cur;
  logic          mdio_hit, loc_hit, clash;
  int            idx_full;
  logic [IW-1:0] mdio_idx;

  assign ptr_cur  = ptr[rf];
  assign mdio_hit = bank_hit(is_c45, rf, ptr_cur, C22_REGS, C45_DEVS, C45_WORDS);
  assign idx_full = bank_index(is_c45, rf, ptr_cur, C22_REGS, C45_WORDS);
  assign mdio_idx = idx_full[IW-1:0];
  assign loc_hit  = int'(loc_addr) < NW;
  assign clash    = wr_evt && mdio_hit && (loc_addr == mdio_idx);

  assign rd_word   = mdio_hit ? bank[mdio_idx] : '0;
  assign loc_rdata = loc_hit ? bank[loc_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
    end else begin
      if (wr_evt && mdio_hit) bank[mdio_idx] <= wdata;
      if (loc_we && loc_hit && !clash) bank[loc_addr] <= loc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (addr_evt) begin
      ptr[rf] <= wdata;
    end else if (inc_evt) begin
      ptr[rf] <= ptr_next(ptr_cur);
    end
  end

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> ptr_cur == $past(ptr_cur) + 16'd1);
  a_r6_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt |=> ptr_cur == $past(wdata));
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !mdio_hit && !loc_we) |=> $stable(bank));
endmodule

// File: rtl/mdio_resp_drive.sv
module mdio_resp_drive import mdio_resp_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_evt,
  input  logic          rd_load,
  input  logic [DW-1:0] rd_word,
  input  phase_e        phase,
  input  logic          rd_frame,
  output logic          mdio_out,
  output logic          mdio_oe
);
  logic [DW:0] tx_sh;
  logic        drive_now;

  assign drive_now = rd_frame && (phase == PH_TA2 || phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (rd_load) begin
      tx_sh <= {1'b0, rd_word};
    end else if (fall_evt) begin
      if (drive_now) begin
        mdio_oe  <= 1'b1;
        mdio_out <= tx_sh[DW];
        tx_sh    <= {tx_sh[DW-1:0], 1'b0};
      end else begin
        mdio_oe  <= 1'b0;
        mdio_out <= 1'b0;
      end
    end
  end

  a_r4_first_drive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> (!mdio_out && phase == PH_TA2 && rd_frame));
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall_evt) |-> $stable(mdio_oe));
  a_r10_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && phase == PH_HUNT) |=> !mdio_oe);
  a_r4_out_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !mdio_out);
endmodule

// File: rtl/mdio_slave_resp.sv
module mdio_slave_resp import mdio_resp_pkg::*; #(
  parameter int C22_REGS    = 8,
  parameter int C45_DEVS    = 2,
  parameter int C45_WORDS   = 8,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NW = C22_REGS + C45_DEVS * C45_WORDS,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    own_addr,
  input  logic          mdc_in,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  input  logic          loc_we,
  input  logic [IW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic          rise_evt, fall_evt, bit_in;
  phase_e        phase;
  logic          rd_frame, is_c45, wr_evt, addr_evt, inc_evt, rd_load;
  logic [4:0]    rf;
  logic [DW-1:0] wdata, rd_word;

  mdio_resp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdio_in(mdio_in),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .bit_in(bit_in));

  mdio_resp_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .bit_in(bit_in),
    .own_addr(own_addr), .phase(phase), .rd_frame(rd_frame), .is_c45(is_c45),
    .rf(rf), .wdata(wdata), .wr_evt(wr_evt), .addr_evt(addr_evt),
    .inc_evt(inc_evt), .rd_load(rd_load));

  mdio_resp_regs #(.C22_REGS(C22_REGS), .C45_DEVS(C45_DEVS), .C45_WORDS(C45_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .is_c45(is_c45), .rf(rf), .wdata(wdata),
    .wr_evt(wr_evt), .addr_evt(addr_evt), .inc_evt(inc_evt), .rd_word(rd_word),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata));

  mdio_resp_drive u_drive (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .rd_load(rd_load),
    .rd_word(rd_word), .phase(phase), .rd_frame(rd_frame),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe));

  a_r5_no_drive_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> rd_frame);
endmodule

// File: tb/test_mdio_slave_resp.sv
module test_mdio_slave_resp;
  localparam int HALF = 8;
  localparam logic [4:0] OWN = 5'h0B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        tb_drv = 1'b0;
  logic        tb_bit = 1'b1;
  logic        mdio_out, mdio_oe, line;
  logic        loc_we = 1'b0;
  logic [4:0]  loc_addr = 5'd0;
  logic [15:0] loc_wdata = 16'h0;
  logic [15:0] loc_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // results of the last frame
  logic [15:0] r_data;
  logic        r_any_oe, r_ta1_oe, r_ta2_oe, r_ta2_v, r_data_oe, r_rel_oe;

  always #4 clk = ~clk;

  assign line = mdio_oe ? mdio_out : (tb_drv ? tb_bit : 1'b1);

  mdio_slave_resp i_mdio_slave_resp (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .mdc_in(mdc), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic drv, input logic b, output logic smp, output logic oe_s);
    @(negedge clk);
    mdc = 1'b0; tb_drv = drv; tb_bit = b;
    repeat (HALF) @(negedge clk);
    smp = line; oe_s = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic c45, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] rf, input logic [1:0] ta, input logic [15:0] wd,
                       input int npre);
    logic s, o;
    logic [11:0] hdr;
    logic rdf;
    rdf = c45 ? op[1] : (op == 2'b10);
    hdr = {op, pa, rf};
    r_any_oe = 1'b0; r_data_oe = 1'b1; r_data = 16'h0;
    for (int i = 0; i < npre; i++) begin bit_cyc(1'b1, 1'b1, s, o); r_any_oe |= o; end
    bit_cyc(1'b1, 1'b0, s, o); r_any_oe |= o;
    bit_cyc(1'b1, !c45, s, o); r_any_oe |= o;
    for (int i = 11; i >= 0; i--) begin bit_cyc(1'b1, hdr[i], s, o); r_any_oe |= o; end
    if (rdf) begin
      bit_cyc(1'b0, 1'b1, s, o); r_ta1_oe = o; r_any_oe |= o;
      bit_cyc(1'b0, 1'b1, s, o); r_ta2_oe = o; r_ta2_v = s; r_any_oe |= o;
      for (int i = 15; i >= 0; i--) begin
        bit_cyc(1'b0, 1'b1, s, o); r_data[i] = s; r_data_oe &= o; r_any_oe |= o;
      end
    end else begin
      bit_cyc(1'b1, ta[1], s, o); r_any_oe |= o;
      bit_cyc(1'b1, ta[0], s, o); r_any_oe |= o;
      for (int i = 15; i >= 0; i--) begin bit_cyc(1'b1, wd[i], s, o); r_any_oe |= o; end
    end
    bit_cyc(1'b0, 1'b1, s, o); r_rel_oe = o;
  endtask

  task automatic loc_write(input int a, input logic [15:0] v);
    @(negedge clk);
    loc_we = 1'b1; loc_addr = a[4:0]; loc_wdata = v;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic loc_read(input int a, output logic [15:0] v);
    @(negedge clk);
    loc_addr = a[4:0];
    #1 v = loc_rdata;
  endtask

  task automatic chk_word(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    loc_read(a, v);
    chk(req, $sformatf("word %0d", a), {16'h0, v}, {16'h0, exp});
  endtask

  task automatic chk_read(input string req, input logic [15:0] exp);
    chk(req, "ta1 undriven", {31'h0, r_ta1_oe}, 32'h0);
    chk(req, "ta2 driven", {31'h0, r_ta2_oe}, 32'h1);
    chk(req, "ta2 level", {31'h0, r_ta2_v}, 32'h0);
    chk(req, "data driven", {31'h0, r_data_oe}, 32'h1);
    chk(req, "read data", {16'h0, r_data}, {16'h0, exp});
    chk(req, "released", {31'h0, r_rel_oe}, 32'h0);
  endtask

  // R1
  task automatic t_reset();
    chk("R1", "oe after reset", {31'h0, mdio_oe}, 32'h0);
    chk("R1", "out after reset", {31'h0, mdio_out}, 32'h0);
    chk_word("R1", 0, 16'h0);
    chk_word("R1", 23, 16'h0);
  endtask

  // R3 R4 R11
  task automatic t_short_format();
    loc_write(2, 16'hA5C3);
    chk_word("R11", 2, 16'hA5C3);
    chk_word("R11", 30, 16'h0);
    frame(1'b0, 2'b10, OWN, 5'd2, 2'b00, 16'h0, 32);
    chk_read("R4", 16'hA5C3);
    frame(1'b0, 2'b01, OWN, 5'd5, 2'b10, 16'h1234, 32);
    chk_word("R3", 5, 16'h1234);
    frame(1'b0, 2'b10, OWN, 5'd5, 2'b00, 16'h0, 32);
    chk_read("R3", 16'h1234);
  endtask

  // R5
  task automatic t_mismatch();
    frame(1'b0, 2'b01, OWN ^ 5'h01, 5'd5, 2'b10, 16'hFFFF, 32);
    chk_word("R5", 5, 16'h1234);
    frame(1'b0, 2'b10, OWN ^ 5'h10, 5'd5, 2'b00, 16'h0, 32);
    chk("R5", "no drive on foreign read", {31'h0, r_any_oe}, 32'h0);
  endtask

  // R6 R8
  task automatic t_extended();
    frame(1'b1, 2'b00, OWN, 5'd1, 2'b10, 16'd3, 32);
    frame(1'b1, 2'b01, OWN, 5'd1, 2'b10, 16'hBEEF, 32);
    chk_word("R6", 11, 16'hBEEF);
    frame(1'b1, 2'b10, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk_read("R6", 16'hBEEF);
    frame(1'b1, 2'b00, OWN, 5'd2, 2'b10, 16'd6, 32);
    frame(1'b1, 2'b01, OWN, 5'd2, 2'b10, 16'h0F0F, 32);
    chk_word("R8", 22, 16'h0F0F);
    frame(1'b1, 2'b10, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk("R8", "dev1 pointer kept", {16'h0, r_data}, {16'h0, 16'hBEEF});
  endtask

  // R7
  task automatic t_increment();
    loc_write(12, 16'h1111);
    loc_write(13, 16'h2222);
    loc_write(16, 16'h7777);
    frame(1'b1, 2'b00, OWN, 5'd1, 2'b10, 16'd4, 32);
    frame(1'b1, 2'b11, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk_read("R7", 16'h1111);
    frame(1'b1, 2'b11, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk("R7", "second post-inc read", {16'h0, r_data}, {16'h0, 16'h2222});
    frame(1'b1, 2'b10, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk("R7", "pointer at 6", {16'h0, r_data}, 32'h0);
    frame(1'b1, 2'b00, OWN, 5'd2, 2'b10, 16'hFFFF, 32);
    frame(1'b1, 2'b11, OWN, 5'd2, 2'b00, 16'h0, 32);
    chk("R7", "read at FFFF", {16'h0, r_data}, 32'h0);
    frame(1'b1, 2'b10, OWN, 5'd2, 2'b00, 16'h0, 32);
    chk("R7", "wrapped to 0", {16'h0, r_data}, {16'h0, 16'h7777});
  endtask

  // R9
  task automatic t_unmapped();
    frame(1'b0, 2'b01, OWN, 5'd20, 2'b10, 16'h4321, 32);
    chk_word("R9", 20, 16'h0);
    frame(1'b0, 2'b10, OWN, 5'd20, 2'b00, 16'h0, 32);
    chk_read("R9", 16'h0);
    frame(1'b1, 2'b00, OWN, 5'd5, 2'b10, 16'd0, 32);
    frame(1'b1, 2'b01, OWN, 5'd5, 2'b10, 16'hABCD, 32);
    chk_word("R9", 8, 16'h0);
    frame(1'b1, 2'b10, OWN, 5'd5, 2'b00, 16'h0, 32);
    chk("R9", "dev5 reads zero", {16'h0, r_data}, 32'h0);
    frame(1'b1, 2'b00, OWN, 5'd1, 2'b10, 16'd100, 32);
    frame(1'b1, 2'b10, OWN, 5'd1, 2'b00, 16'h0, 32);
    chk("R9", "addr 100 reads zero", {16'h0, r_data}, 32'h0);
  endtask

  // R2
  task automatic t_preamble();
    logic s, o;
    bit_cyc(1'b1, 1'b0, s, o);
    frame(1'b0, 2'b01, OWN, 5'd1, 2'b10, 16'h5555, 31);
    chk_word("R2", 1, 16'h0);
    bit_cyc(1'b1, 1'b0, s, o);
    frame(1'b0, 2'b10, OWN, 5'd2, 2'b00, 16'h0, 31);
    chk("R2", "no drive after short preamble", {31'h0, r_any_oe}, 32'h0);
    frame(1'b0, 2'b01, OWN, 5'd1, 2'b10, 16'h5555, 32);
    chk_word("R2", 1, 16'h5555);
  endtask

  // R10
  task automatic t_malformed();
    frame(1'b0, 2'b11, OWN, 5'd1, 2'b10, 16'hFFFF, 32);
    chk_word("R10", 1, 16'h5555);
    chk("R10", "op 11 no drive", {31'h0, r_any_oe}, 32'h0);
    frame(1'b0, 2'b00, OWN, 5'd1, 2'b10, 16'hFFFF, 32);
    chk_word("R10", 1, 16'h5555);
    frame(1'b0, 2'b01, OWN, 5'd1, 2'b00, 16'h0001, 32);
    chk_word("R10", 1, 16'h5555);
    frame(1'b1, 2'b00, OWN, 5'd1, 2'b10, 16'd0, 32);
    frame(1'b1, 2'b01, OWN, 5'd1, 2'b11, 16'h9999, 32);
    chk_word("R10", 8, 16'h0);
    frame(1'b0, 2'b01, OWN, 5'd1, 2'b10, 16'hAAAA, 32);
    chk_word("R10", 1, 16'hAAAA);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_short_format();
    t_mismatch();
    t_extended();
    t_increment();
    t_unmapped();
    t_preamble();
    t_malformed();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule